// File: doc/BRIEF.md
# Packet Transmit Start Controller

This block frames outgoing packets for a radio modem's transmit path. It watches a byte FIFO whose head byte is always visible on `fifo_data` (show-ahead), and a transmit-enable input. When the selected start condition holds, it emits one packet as a serial bit stream, one bit per clock and MSB first. The packet has a run of preamble bytes, then a sync word of 1 to 8 bytes, then a fixed number of payload bytes popped from the FIFO. While the condition is not met, the line is never idle: it carries the preamble pattern or a constant fill bit.

The controller is a state machine with five states. `ST_IDLE` means transmit is disabled and there is no output. `ST_WAIT` means filler is being sent. `ST_PRE`, `ST_SYNC` and `ST_PAY` send the preamble, sync and payload fields. All decisions are taken at byte boundaries, when the serializer is about to need its next byte. The transitions are:
- IDLE or WAIT to PRE, when the condition holds and the preamble length is nonzero.
- IDLE or WAIT to SYNC, when the condition holds and the preamble length is zero.
- IDLE or WAIT to WAIT, when the condition does not hold.
- PRE to SYNC, after the last preamble byte.
- SYNC to PAY, after the last sync byte.
- PAY back to the start decision, when the payload count is reached.
- PAY (or SYNC) to WAIT, on underflow.
- Any state to IDLE, as soon as transmit enable drops.

A separate byte serializer shifts the chosen byte out.

Top module: `pkt_tx_framer`

## Requirements
- R1: While `tx_en` is low, `bit_valid` is 0 from the next clock on, `fifo_pop` is 0, and no byte is taken from the FIFO.
- R2: With `cfg_start_mode` = 1 (first-byte mode), a packet starts at the first byte boundary at which `fifo_level` is at least 1.
- R3: With `cfg_start_mode` = 0 (threshold mode), a packet starts at the first byte boundary at which `fifo_level` is at least `cfg_thresh` + 1. A level equal to `cfg_thresh` does not start it.
- R4: While waiting, each byte sent is 0xAA if `cfg_pre_len` is nonzero, and otherwise eight copies of `cfg_fill_bit`. The start condition is tested only at byte boundaries.
- R5: If the condition already holds when `tx_en` rises, the first byte sent (its first bit valid one clock after `tx_en` is sampled high) is the first byte of the packet.
- R6: A packet is `cfg_pre_len` bytes of 0xAA, then `cfg_sync_len`+1 sync bytes taken from `cfg_sync_word` starting with bits [63:56] and going downward, then the payload. Every byte is sent MSB first.
- R7: Exactly `cfg_pay_len` bytes are popped per packet, with one `fifo_pop` cycle per payload byte. That byte's MSB appears on `bit_out` in the next cycle. After the last payload byte, the start decision is taken again.
- R8: If a payload byte is due while `fifo_level` is 0, `underflow` pulses high for exactly one cycle, the packet is abandoned, and filler follows.
- R9: After reset, `bit_valid`, `fifo_pop` and `underflow` are 0.
- R10: While `tx_en` stays high, `bit_valid` stays high once it has risen, and bytes follow each other with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit mode enable |
| cfg_start_mode | input | 1 | 1 = first-byte start, 0 = threshold start |
| cfg_thresh | input | LVL_W | FIFO threshold; start needs one byte more than this value |
| cfg_pre_len | input | PRE_W | Preamble length in bytes |
| cfg_sync_len | input | SYNC_W | Sync length in bytes minus one |
| cfg_sync_word | input | 8*SYNC_BYTES | Sync bytes, first byte in the top bits |
| cfg_pay_len | input | PAY_W | Payload bytes per packet |
| cfg_fill_bit | input | 1 | Constant bit used while waiting with zero preamble |
| fifo_level | input | LVL_W | Bytes currently held in the FIFO |
| fifo_data | input | 8 | FIFO head byte (show-ahead) |
| fifo_pop | output | 1 | Removes the head byte at the next clock edge |
| bit_out | output | 1 | Serial data, MSB first |
| bit_valid | output | 1 | `bit_out` carries a transmitted bit |
| underflow | output | 1 | One-cycle pulse when the FIFO runs dry mid-payload |

## Verification
The scoreboard checks the bit stream byte by byte against exact filler counts. A design that starts on a level equal to the threshold, or that tests the condition mid-byte, shifts the packet against the filler and fails the comparison.

Other cases targeted:
- A FIFO that still holds bytes after a packet must start the next packet at once and then underflow. This catches designs that pop one byte too many or too few, or that leave `underflow` high.
- Full-length 8-byte sync ordering.
- Zero preamble with fill bits 1 and 0.
- Dropping enable mid-stream, which must silence the line on the next clock.

// File: rtl/txf_pkg.sv
package txf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PRE,
        ST_SYNC,
        ST_PAY
    } txf_state_e;

    localparam logic [7:0] PREAMBLE_BYTE = 8'hAA;

endpackage

// File: rtl/txf_serializer.sv
module txf_serializer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] din,
    input  logic       stop,
    output logic       bit_out,
    output logic       valid,
    output logic       boundary
);

    logic [7:0] shreg;
    logic [2:0] bcnt;
    logic       active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            bcnt   <= '0;
            active <= 1'b0;
        end else if (stop) begin
            active <= 1'b0;
            bcnt   <= '0;
        end else if (load) begin
            shreg  <= din;
            bcnt   <= '0;
            active <= 1'b1;
        end else if (active) begin
            shreg  <= {shreg[6:0], 1'b0};
            bcnt   <= bcnt + 3'd1;
        end
    end

    assign bit_out  = shreg[7];
    assign valid    = active;
    assign boundary = !active || (bcnt == 3'd7);

    // R6: a new byte is only accepted once the current one is fully shifted
    p_load_on_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !stop) |-> (!active || bcnt == 3'd7));

endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl
    import txf_pkg::*;
#(
    parameter int LVL_W      = 7,
    parameter int PRE_W      = 8,
    parameter int PAY_W      = 8,
    parameter int SYNC_BYTES = 8,
    localparam int SYNC_W    = (SYNC_BYTES > 1) ? $clog2(SYNC_BYTES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tx_en,
    input  logic                    boundary,
    input  logic                    cfg_start_mode,
    input  logic [LVL_W-1:0]        cfg_thresh,
    input  logic [PRE_W-1:0]        cfg_pre_len,
    input  logic [SYNC_W-1:0]       cfg_sync_len,
    input  logic [8*SYNC_BYTES-1:0] cfg_sync_word,
    input  logic [PAY_W-1:0]        cfg_pay_len,
    input  logic                    cfg_fill_bit,
    input  logic [LVL_W-1:0]        fifo_level,
    input  logic [7:0]              fifo_data,
    output logic                    fifo_pop,
    output logic                    load,
    output logic [7:0]              load_byte,
    output logic                    stop,
    output logic                    underflow
);

    localparam int CNT_W = ((PRE_W > PAY_W) ? PRE_W : PAY_W) + 1;
    localparam int SW_W  = 8 * SYNC_BYTES;

    txf_state_e       st, nxt_st;
    logic [CNT_W-1:0] idx, nxt_idx;
    logic             uf_set;

    logic             start_ok;
    logic [7:0]       filler;
    logic [SW_W-1:0]  sync_shift;
    logic [CNT_W-1:0] pay_done;
    logic             go_start, go_sync, go_pay;

    assign start_ok = cfg_start_mode ? (fifo_level != '0)
                                     : ({1'b0, fifo_level} > {1'b0, cfg_thresh});
    assign filler   = (cfg_pre_len != '0) ? PREAMBLE_BYTE : {8{cfg_fill_bit}};
    assign sync_shift = cfg_sync_word << {idx, 3'b000};
    assign pay_done = (st == ST_PAY) ? idx : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            idx       <= '0;
            underflow <= 1'b0;
        end else begin
            st        <= nxt_st;
            idx       <= nxt_idx;
            underflow <= uf_set;
        end
    end

    always_comb begin
        nxt_st    = st;
        nxt_idx   = idx;
        load      = 1'b0;
        load_byte = '0;
        stop      = 1'b0;
        fifo_pop  = 1'b0;
        uf_set    = 1'b0;
        go_start  = 1'b0;
        go_sync   = 1'b0;
        go_pay    = 1'b0;

        if (!tx_en) begin
            nxt_st  = ST_IDLE;
            nxt_idx = '0;
            stop    = 1'b1;
        end else if (boundary) begin
            unique case (st)
                ST_IDLE, ST_WAIT: go_start = 1'b1;
                ST_PRE: begin
                    if (idx < CNT_W'(cfg_pre_len)) begin
                        load      = 1'b1;
                        load_byte = PREAMBLE_BYTE;
                        nxt_idx   = idx + CNT_W'(1);
                    end else begin
                        go_sync = 1'b1;
                    end
                end
                ST_SYNC: begin
                    if (idx <= CNT_W'(cfg_sync_len)) begin
                        load      = 1'b1;
                        load_byte = sync_shift[SW_W-1 -: 8];
                        nxt_idx   = idx + CNT_W'(1);
                    end else begin
                        go_pay = 1'b1;
                    end
                end
                ST_PAY: go_pay = 1'b1;
            endcase

            if (go_pay) begin
                if (pay_done < CNT_W'(cfg_pay_len)) begin
                    if (fifo_level != '0) begin
                        fifo_pop  = 1'b1;
                        load      = 1'b1;
                        load_byte = fifo_data;
                        nxt_st    = ST_PAY;
                        nxt_idx   = pay_done + CNT_W'(1);
                    end else begin
                        uf_set    = 1'b1;
                        load      = 1'b1;
                        load_byte = filler;
                        nxt_st    = ST_WAIT;
                        nxt_idx   = '0;
                    end
                end else begin
                    go_start = 1'b1;
                end
            end

            if (go_start) begin
                if (!start_ok) begin
                    load      = 1'b1;
                    load_byte = filler;
                    nxt_st    = ST_WAIT;
                    nxt_idx   = '0;
                end else if (cfg_pre_len != '0) begin
                    load      = 1'b1;
                    load_byte = PREAMBLE_BYTE;
                    nxt_st    = ST_PRE;
                    nxt_idx   = CNT_W'(1);
                end else begin
                    go_sync = 1'b1;
                end
            end

            if (go_sync) begin
                load      = 1'b1;
                load_byte = cfg_sync_word[SW_W-1 -: 8];
                nxt_st    = ST_SYNC;
                nxt_idx   = CNT_W'(1);
            end
        end
    end

    // R8: an underflow abandons the packet and is not repeated on the next cycle
    p_underflow_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (st == ST_WAIT) && !uf_set);

endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer
    import txf_pkg::*;
#(
    parameter int LVL_W      = 7,
    parameter int PRE_W      = 8,
    parameter int PAY_W      = 8,
    parameter int SYNC_BYTES = 8,
    localparam int SYNC_W    = (SYNC_BYTES > 1) ? $clog2(SYNC_BYTES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tx_en,
    input  logic                    cfg_start_mode,
    input  logic [LVL_W-1:0]        cfg_thresh,
    input  logic [PRE_W-1:0]        cfg_pre_len,
    input  logic [SYNC_W-1:0]       cfg_sync_len,
    input  logic [8*SYNC_BYTES-1:0] cfg_sync_word,
    input  logic [PAY_W-1:0]        cfg_pay_len,
    input  logic                    cfg_fill_bit,
    input  logic [LVL_W-1:0]        fifo_level,
    input  logic [7:0]              fifo_data,
    output logic                    fifo_pop,
    output logic                    bit_out,
    output logic                    bit_valid,
    output logic                    underflow
);

    logic       ld, stp, bnd;
    logic [7:0] ld_byte;

    txf_ctrl #(
        .LVL_W(LVL_W), .PRE_W(PRE_W), .PAY_W(PAY_W), .SYNC_BYTES(SYNC_BYTES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .boundary(bnd),
        .cfg_start_mode(cfg_start_mode), .cfg_thresh(cfg_thresh),
        .cfg_pre_len(cfg_pre_len), .cfg_sync_len(cfg_sync_len),
        .cfg_sync_word(cfg_sync_word), .cfg_pay_len(cfg_pay_len),
        .cfg_fill_bit(cfg_fill_bit), .fifo_level(fifo_level),
        .fifo_data(fifo_data), .fifo_pop(fifo_pop), .load(ld),
        .load_byte(ld_byte), .stop(stp), .underflow(underflow)
    );

    txf_serializer u_ser (
        .clk(clk), .rst_n(rst_n), .load(ld), .din(ld_byte), .stop(stp),
        .bit_out(bit_out), .valid(bit_valid), .boundary(bnd)
    );

    // R1: disabling transmit silences the line on the next clock
    p_idle_when_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !bit_valid);

    // R7: a popped byte's MSB is the next bit on the line
    p_pop_feeds_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> bit_valid && (bit_out == $past(fifo_data[7])));

    // R10: no gap in the stream while enabled
    p_no_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && tx_en) |=> bit_valid);

    // R8: underflow is a single-cycle pulse with filler on the line
    p_underflow_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> bit_valid ##1 !underflow);

endmodule

// File: tb/sim_pkt_tx_framer.sv
module sim_pkt_tx_framer;

    localparam int CLK_PERIOD = 10;
    localparam int LVL_W = 7, PRE_W = 8, PAY_W = 8, SYNC_BYTES = 8, SYNC_W = 3;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    tx_en = 1'b0;
    logic                    cfg_start_mode = 1'b1;
    logic [LVL_W-1:0]        cfg_thresh = '0;
    logic [PRE_W-1:0]        cfg_pre_len = '0;
    logic [SYNC_W-1:0]       cfg_sync_len = '0;
    logic [8*SYNC_BYTES-1:0] cfg_sync_word = '0;
    logic [PAY_W-1:0]        cfg_pay_len = '0;
    logic                    cfg_fill_bit = 1'b0;
    logic [LVL_W-1:0]        fifo_level = '0;
    logic [7:0]              fifo_data = '0;
    logic                    fifo_pop, bit_out, bit_valid, underflow;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_tx_framer #(
        .LVL_W(LVL_W), .PRE_W(PRE_W), .PAY_W(PAY_W), .SYNC_BYTES(SYNC_BYTES)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
        .cfg_start_mode(cfg_start_mode), .cfg_thresh(cfg_thresh),
        .cfg_pre_len(cfg_pre_len), .cfg_sync_len(cfg_sync_len),
        .cfg_sync_word(cfg_sync_word), .cfg_pay_len(cfg_pay_len),
        .cfg_fill_bit(cfg_fill_bit), .fifo_level(fifo_level),
        .fifo_data(fifo_data), .fifo_pop(fifo_pop), .bit_out(bit_out),
        .bit_valid(bit_valid), .underflow(underflow)
    );

    int checks = 0, failures = 0;
    int bytes_seen = 0, uf_count = 0, pop_count = 0;
    logic [7:0] fifo_q[$];
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       pop_seen = 1'b0;
    logic [7:0] acc = '0;
    int         bc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic void refresh();
        fifo_level = LVL_W'(fifo_q.size());
        fifo_data  = (fifo_q.size() != 0) ? fifo_q[0] : 8'h00;
    endfunction

    task automatic push_fifo(input logic [7:0] b);
        fifo_q.push_back(b);
        refresh();
    endtask

    task automatic expect_byte(input logic [7:0] b, input string tag);
        exp_q.push_back(b);
        tag_q.push_back(tag);
    endtask

    // FIFO model: pops land after the edge that took the byte
    always @(posedge clk) pop_seen <= fifo_pop;
    always @(negedge clk) begin
        if (pop_seen && fifo_q.size() != 0) begin
            void'(fifo_q.pop_front());
            pop_count++;
            refresh();
        end
    end

    // Monitor: assemble bytes and compare against the scoreboard
    always @(negedge clk) begin
        if (underflow) uf_count++;
        if (bit_valid) begin
            acc = {acc[6:0], bit_out};
            bc++;
            if (bc == 8) begin
                bc = 0;
                bytes_seen++;
                if (exp_q.size() != 0) begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(acc == e, t, acc, e);
                end
            end
        end else begin
            bc = 0;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_bytes(input int target);
        while (bytes_seen < target) tick(1);
    endtask

    task automatic drain(input string tag);
        int t = 0;
        while (exp_q.size() != 0 && t < 3000) begin
            tick(1);
            t++;
        end
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    task automatic quiesce();
        tick(1);
        tx_en = 1'b0;
        tick(3);
        fifo_q.delete();
        exp_q.delete();
        tag_q.delete();
        refresh();
        uf_count = 0;
        pop_count = 0;
    endtask

    bit done = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int base;
        tick(3);
        // R9: reset state
        chk(bit_valid == 1'b0, "R9 bit_valid in reset", bit_valid, 0);
        chk(fifo_pop == 1'b0, "R9 fifo_pop in reset", fifo_pop, 0);
        rst_n = 1'b1;
        tick(2);
        chk(bit_valid == 1'b0 && underflow == 1'b0, "R9 after reset", bit_valid, 0);

        // R1: disabled with data in FIFO; then R5/R6/R7/R8 on enable
        cfg_start_mode = 1'b1; cfg_pre_len = 8'd2; cfg_sync_len = 3'd1;
        cfg_sync_word = {8'h2D, 8'hD4, 48'h0}; cfg_pay_len = 8'd3; cfg_fill_bit = 1'b0;
        push_fifo(8'h11); push_fifo(8'h22); push_fifo(8'h33); push_fifo(8'h44);
        begin
            int seen_v = 0;
            for (int i = 0; i < 20; i++) begin
                tick(1);
                if (bit_valid || fifo_pop) seen_v++;
            end
            chk(seen_v == 0, "R1 silent while disabled", seen_v, 0);
            chk(fifo_q.size() == 4, "R1 nothing popped while disabled", fifo_q.size(), 4);
        end
        expect_byte(8'hAA, "R5 immediate start preamble");
        expect_byte(8'hAA, "R6 preamble byte 2");
        expect_byte(8'h2D, "R6 sync byte 0");
        expect_byte(8'hD4, "R6 sync byte 1");
        expect_byte(8'h11, "R7 payload 0");
        expect_byte(8'h22, "R7 payload 1");
        expect_byte(8'h33, "R7 payload 2");
        expect_byte(8'hAA, "R7 second packet preamble");
        expect_byte(8'hAA, "R7 second packet preamble 2");
        expect_byte(8'h2D, "R6 second sync 0");
        expect_byte(8'hD4, "R6 second sync 1");
        expect_byte(8'h44, "R7 second payload");
        expect_byte(8'hAA, "R8 filler after underflow");
        expect_byte(8'hAA, "R4 waiting preamble filler");
        tx_en = 1'b1;
        tick(1);
        chk(bit_valid == 1'b1, "R5 valid one clock after enable", bit_valid, 1);
        drain("R6 packet sequence complete");
        chk(uf_count == 1, "R8 single underflow pulse", uf_count, 1);
        chk(pop_count == 4, "R7 pop count", pop_count, 4);
        // R1: drop enable mid-stream
        tx_en = 1'b0;
        tick(1);
        chk(bit_valid == 1'b0, "R1 valid drops after disable", bit_valid, 0);
        quiesce();

        // R2/R4: first-byte mode, zero preamble, fill bit 1
        cfg_start_mode = 1'b1; cfg_pre_len = 8'd0; cfg_sync_len = 3'd0;
        cfg_sync_word = {8'h5A, 56'h0}; cfg_pay_len = 8'd1; cfg_fill_bit = 1'b1;
        expect_byte(8'hFF, "R4 fill ones 0");
        expect_byte(8'hFF, "R4 fill ones 1");
        expect_byte(8'hFF, "R4 fill ones 2");
        expect_byte(8'h5A, "R2 sync after first byte");
        expect_byte(8'h77, "R2 payload");
        expect_byte(8'hFF, "R7 back to waiting");
        base = bytes_seen;
        tx_en = 1'b1;
        wait_bytes(base + 2);
        tick(3);
        push_fifo(8'h77);
        drain("R2 first-byte frame");
        quiesce();

        // R3: threshold mode, level equal to threshold must not start
        cfg_start_mode = 1'b0; cfg_thresh = 7'd2; cfg_pre_len = 8'd1;
        cfg_sync_len = 3'd1; cfg_sync_word = {8'h2D, 8'hD4, 48'h0};
        cfg_pay_len = 8'd3; cfg_fill_bit = 1'b0;
        push_fifo(8'h01);
        for (int i = 0; i < 5; i++) expect_byte(8'hAA, "R3 waiting below threshold");
        expect_byte(8'hAA, "R3 preamble after threshold");
        expect_byte(8'h2D, "R3 sync 0");
        expect_byte(8'hD4, "R3 sync 1");
        expect_byte(8'h01, "R3 payload 0");
        expect_byte(8'h02, "R3 payload 1");
        expect_byte(8'h03, "R3 payload 2");
        expect_byte(8'hAA, "R4 filler after packet");
        base = bytes_seen;
        tx_en = 1'b1;
        wait_bytes(base + 1);
        tick(3);
        push_fifo(8'h02);
        wait_bytes(base + 4);
        tick(3);
        push_fifo(8'h03);
        drain("R3 threshold frame");
        chk(uf_count == 0, "R3 no underflow", uf_count, 0);
        quiesce();

        // R6: full 8-byte sync, zero fill bit, preloaded FIFO
        cfg_start_mode = 1'b1; cfg_pre_len = 8'd0; cfg_sync_len = 3'd7;
        cfg_sync_word = 64'h0102_0408_1020_4080; cfg_pay_len = 8'd1; cfg_fill_bit = 1'b0;
        push_fifo(8'h9C);
        for (int i = 0; i < 8; i++) expect_byte(8'h01 << i, "R6 long sync order");
        expect_byte(8'h9C, "R7 payload after long sync");
        expect_byte(8'h00, "R4 fill zeros");
        tx_en = 1'b1;
        drain("R6 long sync frame");
        quiesce();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule